// File: doc/BRIEF.md
# Programmable Input Selection Gate Array

This block is the input stage of a configurable logic cell. A 32-signal pool is split into four groups of eight, and one selector per group picks a single signal. The four picks, in true and inverted form, make up an eight-literal internal bus. Four programmable gates each take the OR of any enabled subset of those literals, and a per-gate polarity bit can invert the result. The four gate outputs feed a downstream logic function, which is not part of this block.

Configuration arrives as static fields held elsewhere: a 16-bit selector word, a 32-bit literal enable mask and a 4-bit polarity vector. The path from pool to gate outputs is purely combinational. Each gate can produce OR, NOR, AND, NAND, or a constant 0 or 1 of its literals. A constant is set by clearing every enable of the gate and choosing the level with its polarity bit.

Top module: `pisg_array`

## Requirements
- R1: Selector k (k = 0..3) drives pick k with `pool_i[8*k + c]`, where c is the 3-bit code at `sel_word_i[4*k+2 : 4*k]`.
- R2: Bits 3, 7, 11 and 15 of `sel_word_i` have no effect on any gate output.
- R3: Gate g (g = 0..3) is controlled by `en_mask_i[8*g+7 : 8*g]`. Inside that byte, bit 2*k+1 enables the true form of pick k and bit 2*k enables its inverted form.
- R4: Each gate output is the OR of its enabled literals, XORed with `pol_i[g]`.
- R5: A gate whose eight enable bits are all zero outputs `pol_i[g]`, whatever the pool holds.
- R6: A gate that enables both the true and the inverted form of the same pick outputs the inverse of `pol_i[g]`, whatever the pool holds.
- R7: A gate byte of 0xAA gives the OR of the four picks with polarity 0, and their NOR with polarity 1.
- R8: A gate byte of 0x55 gives the NAND of the four picks with polarity 0, and their AND with polarity 1.
- R9: The outputs follow any change on the pool or on the configuration without a clock and without latency.
- R10: With an all-zero enable mask and an all-zero polarity vector, every gate output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pool_i | input | 32 | Input signal pool, four groups of eight |
| sel_word_i | input | 16 | Four 3-bit selector codes, each in a 4-bit field |
| en_mask_i | input | 32 | Literal enables, one byte per gate |
| pol_i | input | 4 | Output inversion, one bit per gate |
| gate_o | output | 4 | Gate outputs for the downstream logic function |

## Verification
The bench goes after the bit layout first. A design that swapped the true and inverted enables, or that placed a gate's byte at the wrong offset, would turn the OR and NAND patterns into each other or answer from the wrong gate. The constant cases come next: an empty gate that ignored its polarity bit would stick at 0, and a gate that did not saturate when both forms of one pick are enabled would follow the pool. Finally, the bench sets the unused selector bits. A selector that decoded four bits instead of three would then reach into the neighbouring group and change the picks.

// File: rtl/pisg_pkg.sv
package pisg_pkg;
  // Default geometry: four selectors of eight ways, four gates
  localparam int unsigned DEF_NUM_SEL = 4;
  localparam int unsigned DEF_SEL_W   = 3;
endpackage

// File: rtl/pisg_src_mux.sv
module pisg_src_mux #(
  parameter int unsigned SEL_W = pisg_pkg::DEF_SEL_W
) (
  input  logic [(1<<SEL_W)-1:0] data_i,
  input  logic [SEL_W-1:0]      code_i,
  output logic                  pick_o
);
  always_comb begin
    pick_o = data_i[code_i];
    // a group that is all ones or all zeros leaves no choice
    if (&data_i) begin
      AST_PICK_ALL_HIGH: assert (pick_o == 1'b1); // R1
    end
    if (data_i == '0) begin
      AST_PICK_ALL_LOW: assert (pick_o == 1'b0); // R1
    end
  end
endmodule

// File: rtl/pisg_sop_gate.sv
module pisg_sop_gate #(
  parameter int unsigned NUM_SRC = pisg_pkg::DEF_NUM_SEL,
  localparam int unsigned LIT_N  = 2 * NUM_SRC
) (
  input  logic [LIT_N-1:0] lit_i,
  input  logic [LIT_N-1:0] en_i,
  input  logic             pol_i,
  output logic             y_o
);
  logic [LIT_N-1:0] hit;
  logic             pair_on;

  always_comb begin
    hit     = en_i & lit_i;
    y_o     = (|hit) ^ pol_i;
    pair_on = 1'b0;
    for (int k = 0; k < int'(NUM_SRC); k++) begin
      pair_on = pair_on | (en_i[2*k] & en_i[2*k+1]);
    end
    if (en_i == '0) begin
      AST_EMPTY_GATE_LEVEL: assert (y_o == pol_i); // R5
    end
    if (pair_on) begin
      AST_PAIR_SATURATES: assert (y_o == !pol_i); // R6
    end
    if (y_o != pol_i) begin
      AST_FLIP_NEEDS_ENABLE: assert (en_i != '0); // R4
    end
  end
endmodule

// File: rtl/pisg_array.sv
module pisg_array #(
  parameter int unsigned NUM_SEL  = pisg_pkg::DEF_NUM_SEL,
  parameter int unsigned SEL_W    = pisg_pkg::DEF_SEL_W,
  localparam int unsigned WAY     = 1 << SEL_W,
  localparam int unsigned POOL_W  = NUM_SEL * WAY,
  localparam int unsigned FIELD_W = SEL_W + 1,
  localparam int unsigned SELWD_W = NUM_SEL * FIELD_W,
  localparam int unsigned LIT_N   = 2 * NUM_SEL,
  localparam int unsigned MASK_W  = NUM_SEL * LIT_N
) (
  input  logic [POOL_W-1:0]  pool_i,
  input  logic [SELWD_W-1:0] sel_word_i,
  input  logic [MASK_W-1:0]  en_mask_i,
  input  logic [NUM_SEL-1:0] pol_i,
  output logic [NUM_SEL-1:0] gate_o
);
  logic [NUM_SEL-1:0] pick;
  logic [LIT_N-1:0]   lit_bus;
  logic [NUM_SEL-1:0] pad_bits;
  logic               unused_pad;

  // selectors, one per group of the pool
  for (genvar k = 0; k < int'(NUM_SEL); k++) begin : g_src
    pisg_src_mux #(.SEL_W(SEL_W)) u_mux (
      .data_i (pool_i[k*WAY +: WAY]),
      .code_i (sel_word_i[k*FIELD_W +: SEL_W]),
      .pick_o (pick[k])
    );
    assign pad_bits[k]    = sel_word_i[k*FIELD_W + SEL_W];
    assign lit_bus[2*k+1] = pick[k];
    assign lit_bus[2*k]   = ~pick[k];
  end

  assign unused_pad = ^pad_bits;

  // programmable sum gates, one byte of the mask each
  for (genvar g = 0; g < int'(NUM_SEL); g++) begin : g_gate
    pisg_sop_gate #(.NUM_SRC(NUM_SEL)) u_gate (
      .lit_i (lit_bus),
      .en_i  (en_mask_i[g*LIT_N +: LIT_N]),
      .pol_i (pol_i[g]),
      .y_o   (gate_o[g])
    );
  end

  always_comb begin
    if (en_mask_i == '0 && pol_i == '0) begin
      AST_IDLE_CONFIG_LOW: assert (gate_o == '0); // R10
    end
    if (en_mask_i == '0) begin
      AST_IDLE_MASK_POL: assert (gate_o == pol_i); // R5
    end
  end
endmodule

// File: tb/pisg_array_bench.sv
module pisg_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_RUNS  = 3000;

  logic        clk;
  logic [31:0] pool;
  logic [15:0] selw;
  logic [31:0] mask;
  logic [3:0]  pol;
  logic [3:0]  gout;
  int          n_checks;
  int          n_errors;
  bit          done;

  pisg_array u_pisg_array (
    .pool_i     (pool),
    .sel_word_i (selw),
    .en_mask_i  (mask),
    .pol_i      (pol),
    .gate_o     (gout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference built from the requirements
  function automatic logic [3:0] ref_out(input logic [31:0] p, input logic [15:0] s,
                                         input logic [31:0] m, input logic [3:0] v);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) begin
      bit acc = 0;
      for (int k = 0; k < 4; k++) begin
        int c = (s >> (4*k)) & 7;
        bit d = p[8*k + c];
        if (m[8*g + 2*k + 1] && d)  acc = 1;
        if (m[8*g + 2*k] && !d)     acc = 1;
      end
      r[g] = acc ^ v[g];
    end
    return r;
  endfunction

  task automatic apply(input logic [31:0] p, input logic [15:0] s,
                       input logic [31:0] m, input logic [3:0] v);
    @(posedge clk);
    #1;
    pool = p; selw = s; mask = m; pol = v;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    n_checks++;
    if (gout !== exp) begin
      n_errors++;
      $display("FAIL %s: gate_o=%b expected %b (pool=%h sel=%h mask=%h pol=%b)",
               tag, gout, exp, pool, selw, mask, pol);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] first;
    n_checks = 0; n_errors = 0; done = 0;
    pool = '0; selw = '0; mask = '0; pol = '0;

    // R10: idle configuration, any pool
    apply(32'hFFFF_FFFF, 16'h0000, 32'h0, 4'h0);
    check("R10", 4'b0000);
    apply(32'h5A5A_A5A5, 16'h7777, 32'h0, 4'h0);
    check("R10", 4'b0000);

    // R5: empty gates give their polarity bit
    apply(32'hDEAD_BEEF, 16'h1234, 32'h0, 4'b1010);
    check("R5", 4'b1010);
    apply(32'h0, 16'h0, 32'h0, 4'b0111);
    check("R5", 4'b0111);

    // R1/R3: gate 0 takes only true pick 0, code 5 -> pool[5]
    apply(32'h0000_0020, 16'h0005, 32'h0000_0002, 4'h0);
    check("R1", 4'b0001);
    apply(32'h0000_0010, 16'h0005, 32'h0000_0002, 4'h0);
    check("R1", 4'b0000);
    // R1/R3: gate 2 takes true pick 3, code 6 -> pool[30]
    apply(32'h4000_0000, 16'h6000, 32'h0080_0000, 4'h0);
    check("R3", 4'b0100);
    // R3: gate 3 takes inverted pick 1, code 2 -> pool[10] low
    apply(32'h0000_0000, 16'h0020, 32'h0400_0000, 4'h0);
    check("R3", 4'b1000);
    apply(32'h0000_0400, 16'h0020, 32'h0400_0000, 4'h0);
    check("R3", 4'b0000);

    // R2: unused selector bits leave outputs unchanged
    apply(32'h8421_1248, 16'h3152, 32'hA5C3_9E17, 4'b0110);
    first = gout;
    check("R2", ref_out(32'h8421_1248, 16'h3152, 32'hA5C3_9E17, 4'b0110));
    apply(32'h8421_1248, 16'hB9DA, 32'hA5C3_9E17, 4'b0110);
    check("R2", first);

    // R6: both forms of one pick enabled saturate the gate
    apply(32'h0, 16'h0, 32'h0000_0003, 4'h0);
    check("R6", 4'b0001);
    apply(32'hFFFF_FFFF, 16'h7777, 32'hC000_0000, 4'b1000);
    check("R6", 4'b0000);

    // R7: 0xAA byte, OR / NOR of picks (sel 0: pool bits 0,8,16,24)
    apply(32'h0000_0000, 16'h0, 32'hAAAA_AAAA, 4'b0000);
    check("R7", 4'b0000);
    apply(32'h0001_0000, 16'h0, 32'hAAAA_AAAA, 4'b0000);
    check("R7", 4'b1111);
    apply(32'h0001_0000, 16'h0, 32'hAAAA_AAAA, 4'b1111);
    check("R7", 4'b0000);

    // R8: 0x55 byte, NAND / AND of picks
    apply(32'h0101_0101, 16'h0, 32'h5555_5555, 4'b1111);
    check("R8", 4'b1111);
    apply(32'h0101_0001, 16'h0, 32'h5555_5555, 4'b1111);
    check("R8", 4'b0000);
    apply(32'h0101_0101, 16'h0, 32'h5555_5555, 4'b0000);
    check("R8", 4'b0000);

    // R9: input change seen in the same cycle, then random sweep (R4)
    pool = 32'h0000_0001; selw = '0; mask = 32'h0000_0002; pol = '0;
    #1;
    check("R9", 4'b0001);
    pool = 32'h0000_0000;
    #1;
    check("R9", 4'b0000);

    for (int i = 0; i < RAND_RUNS; i++) begin
      logic [31:0] rp, rm;
      logic [15:0] rs;
      logic [3:0]  rv;
      rp = $urandom; rs = 16'($urandom); rm = $urandom; rv = 4'($urandom);
      if (i % 4 == 1) rm = rm & $urandom;
      apply(rp, rs, rm, rv);
      check("R4", ref_out(rp, rs, rm, rv));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule